// File: doc/BRIEF.md
# Delayed even-parity checker with cascade support

This block checks even parity over a configurable subset of a registered data word. The parity bit for a word reaches the block one clock after the word itself. The block therefore reduces the checked bits of each word to a single parity bit as soon as the word is registered. It delays that one bit until the late parity input for the same word arrives, and combines the two. The result appears on a partial-parity output (`ppo`) and on an active-low error flag (`err_n`). The flag stays low for two cycles once a mismatch is seen.

Two select pins choose which bits are checked and how late the parity input is taken. On its own, one instance uses select value 00 and checks a wide subset. For a wider word, two instances are chained. The upstream instance uses value 01 and checks one half. Its `ppo` drives the `par_in` of the downstream instance, which uses value 11 and checks the other half. The downstream instance takes its parity input two cycles later than a stand-alone instance, so the upstream `ppo` lines up with the same word. Only the downstream `err_n` carries the final verdict.

In the requirements, Dk names `data_in[k-1]`. The select value is written as {`sel_pos`, `sel_half`}.

Top module: `dlypar_chk`

## Requirements
- R1: For each word, `ppo` equals the XOR of the word's checked bits and the parity bit aligned to that word. So `ppo`=1 means the checked bits plus the parity bit hold an odd number of ones. `err_n` goes low at the same edge that registers `ppo`=1.
- R2: With select 00, and also with the spare value 10, the checked bits are D2, D3, D5, D6 and D8 to D25. Every other data bit has no effect on `ppo`.
- R3: With select 01, the checked bits are D2, D3, D5, D6 and D8 to D14. Every other data bit has no effect.
- R4: With select 11, the checked bits are D1 to D6 and D8 to D13. Every other data bit has no effect.
- R5: With any select value other than 11, `par_in` is sampled at the first rising edge after the edge that registers the word. `ppo` and `err_n` for that word update at the second rising edge after it.
- R6: With select 11, `par_in` is sampled at the third rising edge after the data edge. `ppo` and `err_n` update at the fourth edge. This matches the timing of an upstream `ppo` wired straight to `par_in`.
- R7: `err_n` is low for exactly two cycles after an edge that registers an error. Another error edge restarts the two-cycle window. Otherwise `err_n` is high.
- R8: `rst_n` low resets the block asynchronously. `ppo` becomes 0 and `err_n` becomes 1. The whole pipeline is cleared, so no word from before the reset is reported after the reset is released.
- R9: In a chain of an upstream instance (select 01) and a downstream instance (select 11) that are fed correct parity, flipping one checked bit of one word in either half gives exactly one low pulse on the downstream `err_n`. That pulse starts at the fourth edge after the word and lasts two cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel_pos | input | 1 | Chain-position select bit (high on the downstream instance) |
| sel_half | input | 1 | Half-width select bit (high on both chained instances) |
| data_in | input | DATA_W (25) | Data word, sampled every rising edge; Dk is bit k-1 |
| par_in | input | 1 | Late parity bit for an earlier word, or upstream `ppo` |
| ppo | output | 1 | Partial parity of checked bits and aligned parity |
| err_n | output | 1 | Active-low parity error flag, held two cycles |

## Verification
On every cycle, the assertions check several things. `ppo` must equal the checked-bit parity and the parity input taken the right number of edges earlier, for both the near and the far alignment. Every fall of `err_n` must come from a registered `ppo` of 1 and must last at least two cycles, and reset must clear both outputs. Only the bench scenarios can show the rest. These cover which data bits each select value includes or ignores, and the walking single bit across all 25 positions. They also cover the two-instance chain, where one flipped bit in either half must give exactly one error pulse at the predicted cycle, and the case where a reset arrives while the flag is low.

// File: rtl/parchk_pkg.sv
package parchk_pkg;

    localparam int FULL_TOP_D = 25;
    localparam int HALF_TOP_D = 14;
    localparam int DOWN_TOP_D = 13;

    typedef enum logic [1:0] {
        MODE_FULL = 2'b00,
        MODE_UP   = 2'b01,
        MODE_SPR  = 2'b10,
        MODE_DOWN = 2'b11
    } sel_mode_e;

    // 1-based bit number d is part of the checked subset for mode m
    function automatic logic bit_checked(sel_mode_e m, int d);
        logic low_grp;
        low_grp = (d == 2) || (d == 3) || (d == 5) || (d == 6);
        case (m)
            MODE_DOWN: return ((d >= 1) && (d <= 6)) || ((d >= 8) && (d <= DOWN_TOP_D));
            MODE_UP:   return low_grp || ((d >= 8) && (d <= HALF_TOP_D));
            default:   return low_grp || ((d >= 8) && (d <= FULL_TOP_D));
        endcase
    endfunction

endpackage

// File: rtl/parchk_mask.sv
module parchk_mask
    import parchk_pkg::*;
#(
    parameter int DATA_W = 25
) (
    input  logic [DATA_W-1:0] data_in,
    input  sel_mode_e         mode,
    output logic              sub_par
);

    logic [DATA_W-1:0] m_full;
    logic [DATA_W-1:0] m_up;
    logic [DATA_W-1:0] m_down;
    logic [DATA_W-1:0] m_sel;

    for (genvar i = 0; i < DATA_W; i++) begin : g_mask
        assign m_full[i] = bit_checked(MODE_FULL, i + 1);
        assign m_up[i]   = bit_checked(MODE_UP,   i + 1);
        assign m_down[i] = bit_checked(MODE_DOWN, i + 1);
    end

    always_comb begin
        case (mode)
            MODE_UP:   m_sel = m_up;
            MODE_DOWN: m_sel = m_down;
            default:   m_sel = m_full;
        endcase
        sub_par = ^(data_in & m_sel);
    end

endmodule

// File: rtl/parchk_align.sv
module parchk_align #(
    parameter int NEAR_LAG = 1,
    parameter int FAR_LAG  = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sub_par,
    input  logic par_in,
    input  logic far,
    output logic aligned
);

    localparam int DEPTH = FAR_LAG + 1;

    typedef struct packed {
        logic [DEPTH-1:0] dp;
        logic             par;
    } align_st_t;

    align_st_t s_d, s_q;

    always_comb begin
        s_d     = s_q;
        s_d.dp  = {s_q.dp[DEPTH-2:0], sub_par};
        s_d.par = par_in;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign aligned = s_q.par ^ (far ? s_q.dp[FAR_LAG] : s_q.dp[NEAR_LAG]);

endmodule

// File: rtl/parchk_flag.sv
module parchk_flag #(
    parameter int HOLD = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic aligned,
    output logic ppo,
    output logic err_n
);

    localparam int CW = $clog2(HOLD + 1);

    typedef struct packed {
        logic          ppo;
        logic [CW-1:0] hold;
    } flag_st_t;

    flag_st_t s_d, s_q;

    always_comb begin
        s_d     = s_q;
        s_d.ppo = aligned;
        if (aligned)
            s_d.hold = CW'(HOLD);
        else if (s_q.hold != '0)
            s_d.hold = s_q.hold - CW'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign ppo   = s_q.ppo;
    assign err_n = (s_q.hold == '0);

    // R1
    err_on_ppo_chk: assert property (@(posedge clk) disable iff (!rst_n) ppo |-> !err_n);

    // R7
    err_src_chk: assert property (@(posedge clk) disable iff (!rst_n) $fell(err_n) |-> ppo);

    // R8
    rst_clear_chk: assert property (@(posedge clk) !rst_n |=> (!ppo && err_n));

    if (HOLD >= 2) begin : g_hold_chk
        // R7
        err_hold_chk: assert property (@(posedge clk) disable iff (!rst_n) $fell(err_n) |=> !err_n);
    end

endmodule

// File: rtl/dlypar_chk.sv
module dlypar_chk
    import parchk_pkg::*;
#(
    parameter int DATA_W        = 25,
    parameter int NEAR_LAG      = 1,
    parameter int CASCADE_EXTRA = 2,
    parameter int ERR_HOLD      = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel_pos,
    input  logic              sel_half,
    input  logic [DATA_W-1:0] data_in,
    input  logic              par_in,
    output logic              ppo,
    output logic              err_n
);

    localparam int FAR_LAG = NEAR_LAG + CASCADE_EXTRA;

    sel_mode_e mode;
    logic      far;
    logic      sub_par;
    logic      aligned;

    assign mode = sel_mode_e'({sel_pos, sel_half});
    assign far  = sel_pos & sel_half;

    parchk_mask #(.DATA_W(DATA_W)) u_mask (
        .data_in (data_in),
        .mode    (mode),
        .sub_par (sub_par)
    );

    parchk_align #(.NEAR_LAG(NEAR_LAG), .FAR_LAG(FAR_LAG)) u_align (
        .clk     (clk),
        .rst_n   (rst_n),
        .sub_par (sub_par),
        .par_in  (par_in),
        .far     (far),
        .aligned (aligned)
    );

    parchk_flag #(.HOLD(ERR_HOLD)) u_flag (
        .clk     (clk),
        .rst_n   (rst_n),
        .aligned (aligned),
        .ppo     (ppo),
        .err_n   (err_n)
    );

    // edges since reset release, saturating; guards the end-to-end checks
    logic [2:0] warm_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              warm_q <= '0;
        else if (warm_q != 3'd7) warm_q <= warm_q + 3'd1;
    end

    if (NEAR_LAG == 1 && FAR_LAG == 3) begin : g_lag_chk
        // R5
        near_lag_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (warm_q >= 3'd3 && !far) |-> (ppo == ($past(sub_par, 3) ^ $past(par_in, 2))));
        // R6
        far_lag_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (warm_q >= 3'd5 && far) |-> (ppo == ($past(sub_par, 5) ^ $past(par_in, 2))));
    end

endmodule

// File: tb/sim_dlypar_chk.sv
module sim_dlypar_chk;

    localparam int W = 25;

    typedef struct {
        int    due;
        bit    ppo;
        string tag;
    } item_t;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic         rst_n;
    logic         sel_pos, sel_half;
    logic [W-1:0] d0;
    logic         p0;
    logic         ppo0, errn0;

    logic [W-1:0] dA, dB;
    logic         pA;
    logic         ppoA, errA, ppoB, errB;

    dlypar_chk u0 (
        .clk(clk), .rst_n(rst_n), .sel_pos(sel_pos), .sel_half(sel_half),
        .data_in(d0), .par_in(p0), .ppo(ppo0), .err_n(errn0)
    );

    dlypar_chk u_up (
        .clk(clk), .rst_n(rst_n), .sel_pos(1'b0), .sel_half(1'b1),
        .data_in(dA), .par_in(pA), .ppo(ppoA), .err_n(errA)
    );

    dlypar_chk u_dn (
        .clk(clk), .rst_n(rst_n), .sel_pos(1'b1), .sel_half(1'b1),
        .data_in(dB), .par_in(ppoA), .ppo(ppoB), .err_n(errB)
    );

    int      n_chk  = 0;
    int      n_fail = 0;
    int      cyc    = 0;
    int      lag    = 1;
    bit [1:0] mode_b = 2'b00;
    bit      chk_en  = 1'b0;
    bit      casc_en = 1'b0;
    int      hold_m  = 0;
    item_t   q[$];
    bit      par_sched[int];
    bit      rec_err[int];

    task automatic check(input bit ok, input string tag, input int got, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s got %0d expected %0d (cycle %0d)", tag, got, exp, cyc);
        end
    endtask

    // checked-bit mask written from the requirements: Dk is bit k-1
    function automatic logic [W-1:0] exp_mask(input logic [1:0] m);
        logic [W-1:0] r;
        bit on;
        r = '0;
        for (int d = 1; d <= W; d++) begin
            if (m == 2'b11)      on = (d <= 6) || (d >= 8 && d <= 13);        // R4
            else if (m == 2'b01) on = d == 2 || d == 3 || d == 5 || d == 6 ||
                                      (d >= 8 && d <= 14);                    // R3
            else                 on = d == 2 || d == 3 || d == 5 || d == 6 ||
                                      d >= 8;                                 // R2
            r[d-1] = on;
        end
        return r;
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) cyc <= 0;
        else        cyc <= cyc + 1;
    end

    // monitor: pops expected ppo per edge, models the two-cycle error window
    always @(negedge clk) begin
        bit    e;
        string t;
        if (!rst_n) hold_m = 0;
        else if (chk_en) begin
            e = 1'b0;
            t = (cyc <= 5) ? "R8" : "R1";
            if (q.size() > 0 && q[0].due == cyc) begin
                e = q[0].ppo;
                t = q[0].tag;
                void'(q.pop_front());
            end
            check(ppo0 === e, t, int'(ppo0), int'(e));
            if (e) hold_m = 2;
            else if (hold_m > 0) hold_m--;
            check(errn0 === (hold_m == 0), "R7", int'(errn0), int'(hold_m == 0));
        end
    end

    always @(negedge clk) begin
        if (casc_en && rst_n) rec_err[cyc] = errB;
    end

    // driver: one word per cycle; its parity is scheduled lag edges later
    task automatic send(input logic [W-1:0] w, input bit flip, input string tag);
        int    n;
        bit    s;
        item_t it;
        n  = cyc + 1;
        d0 = w;
        p0 = par_sched.exists(n) ? par_sched[n] : 1'b0;
        s  = ^(w & exp_mask(mode_b));
        par_sched[n + lag] = s ^ flip;
        it.due = n + lag + 1;
        it.ppo = flip;
        it.tag = tag;
        q.push_back(it);
        @(negedge clk);
    endtask

    task automatic idle();
        int n;
        n  = cyc + 1;
        d0 = '0;
        dA = '0;
        dB = '0;
        p0 = par_sched.exists(n) ? par_sched[n] : 1'b0;
        pA = par_sched.exists(n) ? par_sched[n] : 1'b0;
        @(negedge clk);
    endtask

    task automatic apply_reset(input bit [1:0] m);
        rst_n    = 1'b0;
        mode_b   = m;
        sel_pos  = m[1];
        sel_half = m[0];
        lag      = (m == 2'b11) ? 3 : 1;
        d0 = '0; p0 = 1'b0; dA = '0; dB = '0; pA = 1'b0;
        q.delete();
        par_sched.delete();
        repeat (2) @(negedge clk);
        // R8 reset state on all three instances
        check(ppo0 === 1'b0 && ppoA === 1'b0 && ppoB === 1'b0, "R8", int'(ppo0 | ppoA | ppoB), 0);
        check(errn0 === 1'b1 && errA === 1'b1 && errB === 1'b1, "R8", int'(errn0 & errA & errB), 1);
        rst_n = 1'b1;
    endtask

    task automatic run_mode(input bit [1:0] m, input string tag);
        logic [W-1:0] w;
        apply_reset(m);
        chk_en = 1'b1;
        // walking one with parity 0: ppo equals subset membership of that bit
        for (int i = 0; i < W; i++) begin
            w = W'(1) << i;
            send(w, ^(w & exp_mask(m)), tag);
        end
        for (int i = 0; i < 30; i++) begin
            w = W'($urandom);
            send(w, ($urandom % 4) == 0, tag);
        end
        for (int i = 0; i < lag + 3; i++) idle();
        chk_en = 1'b0;
    endtask

    task automatic run_cascade(input bit flip_dn, input string tag);
        logic [W-1:0] a, b;
        int n, flip_n, falls, lows;
        bit prev;
        apply_reset(2'b00);
        rec_err.delete();
        casc_en = 1'b1;
        flip_n  = 0;
        for (int i = 0; i < 12; i++) begin
            n = cyc + 1;
            a = W'($urandom);
            b = W'($urandom);
            par_sched[n + 1] = (^(a & exp_mask(2'b01))) ^ (^(b & exp_mask(2'b11)));
            if (i == 5) begin
                if (flip_dn) b = b ^ W'(1);      // D1, checked downstream
                else         a = a ^ W'(2);      // D2, checked upstream
                flip_n = n;
            end
            dA = a;
            dB = b;
            pA = par_sched.exists(n) ? par_sched[n] : 1'b0;
            @(negedge clk);
        end
        for (int i = 0; i < 8; i++) idle();
        casc_en = 1'b0;
        falls = 0;
        lows  = 0;
        prev  = 1'b1;
        for (int c = 1; c <= cyc; c++) begin
            if (rec_err.exists(c)) begin
                check(rec_err[c] === ((c == flip_n + 4) || (c == flip_n + 5) ? 1'b0 : 1'b1),
                      tag, int'(rec_err[c]), int'(!((c == flip_n + 4) || (c == flip_n + 5))));
                if (prev && !rec_err[c]) falls++;
                if (!rec_err[c]) lows++;
                prev = rec_err[c];
            end
        end
        check(falls == 1, tag, falls, 1);
        check(lows == 2, tag, lows, 2);
    endtask

    initial begin
        rst_n = 1'b0;
        sel_pos = 1'b0; sel_half = 1'b0;
        d0 = '0; p0 = 1'b0; dA = '0; dB = '0; pA = 1'b0;
        @(negedge clk);
        run_mode(2'b00, "R2/R5");
        run_mode(2'b01, "R3/R5");
        run_mode(2'b11, "R4/R6");
        run_mode(2'b10, "R2/R5");

        // R8: reset while the error flag is low clears both outputs at once
        apply_reset(2'b00);
        chk_en = 1'b1;
        for (int i = 0; i < 4; i++) send(W'($urandom), 1'b0, "R1");
        send(W'($urandom), 1'b1, "R1");
        send('0, 1'b0, "R1");
        send('0, 1'b0, "R1");
        chk_en = 1'b0;
        check(errn0 === 1'b0, "R8", int'(errn0), 0);
        #1 rst_n = 1'b0;
        #1;
        check(ppo0 === 1'b0 && errn0 === 1'b1, "R8", int'({ppo0, errn0}), 1);
        @(negedge clk);

        // R9: one flipped bit in the upstream half, then in the downstream half
        run_cascade(1'b0, "R9");
        run_cascade(1'b1, "R9");

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL R1 watchdog got timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule